// File: doc/BRIEF.md
# CEC Receive Acknowledge and Error-Bit Policy

This block sits beside a CEC bit-timing receiver and makes the per-frame protocol decisions for it. When the receiver presents the header byte of a new frame, the block decodes the destination field and compares it with the device's own logical addresses. It then decides three things: whether the frame is taken in, whether the device pulls the acknowledge bit low, and which errors count for this frame. The own addresses are held as a bitmap, so a device may answer to several addresses at once. A listening-mode input selects one of two behaviours. In reduced listening mode, only frames for the device itself and broadcast frames are taken in. In full listening mode, every frame is taken in, but only frames for the device's own addresses are acknowledged.

While a frame is in progress, the timing receiver reports three kinds of bit-level error as single-cycle pulses: a rising edge at the wrong time, a bit period that is too short, and a bit period that is too long. The block applies four configuration bits to these pulses:

- stop the reception on a rising error;
- send an error bit on a rising error;
- send an error bit on a long period;
- suppress error bits on broadcast frames.

From them it requests an error bit on the line, ends the reception when that is configured, and records each error kind in a flag that stays set until it is cleared by writing 1. Broadcast frames follow their own rule, and the broadcast suppression bit overrides the per-error enables. Frames for another device are received in full listening mode without any effect on the bus. The payload after the header may run from 0 to 15 bytes; the block does not count payload bytes. It only holds the frame context until the receiver signals the end of the frame.

Top module: `cec_rx_policy`

## Requirements
- R1: In reduced listening mode (listen_all = 0), accept rises in the cycle after hdr_valid exactly when the destination field (hdr_byte[3:0]) is 15 (broadcast) or own_map[destination] is 1; for any other destination accept stays 0.
- R2: In full listening mode (listen_all = 1), every header makes accept 1 in the following cycle. own_map may hold several set bits, and each set bit k makes logical address k an own address.
- R3: ack_drive is 1 for an accepted frame exactly when its destination is an own address other than 15. Broadcast frames are never acknowledged (the line is left high), and frames for other destinations accepted in full listening mode are never acknowledged.
- R4: accept and ack_drive keep their value for the whole frame and fall in the cycle after a frame_done pulse.
- R5: A rising error during an accepted frame with cfg_stop_on_rise = 1 gives a one-cycle rx_stop pulse in the next cycle, and accept falls in that same cycle. With cfg_stop_on_rise = 0, rx_stop stays 0 and the frame stays accepted.
- R6: For a frame addressed to an own address, a rising error requests an error bit (err_bit_req one cycle later) only when cfg_ebit_rise and cfg_stop_on_rise are both 1.
- R7: For a frame addressed to an own address, a long-period error requests an error bit only when cfg_ebit_long is 1. It does not stop the reception.
- R8: For a broadcast frame with cfg_bcast_no_ebit = 0, a rising error requests an error bit whenever cfg_stop_on_rise = 1, and a long-period error always requests one, whatever the per-error enables are. With cfg_bcast_no_ebit = 1, neither error requests an error bit on a broadcast frame.
- R9: A short-period error requests an error bit for frames addressed to an own address and for broadcast frames received in reduced listening mode. It requests none for a broadcast frame received in full listening mode.
- R10: Error pulses have no effect when no frame is accepted, or when they arrive in the same cycle as hdr_valid. Frames for other destinations in full listening mode never cause an error bit.
- R11: err_flags bit 0 (rising), bit 1 (short period) and bit 2 (long period) are set in the cycle after the matching error arrives during an accepted frame. A bit stays set until flag_clr has a 1 at that position. If a set and a clear reach the same bit in one cycle, the set wins.
- R12: The initiator field hdr_byte[7:4] has no effect on accept or ack_drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | One-cycle pulse: hdr_byte holds a new frame header |
| hdr_byte | input | 8 | Header byte: initiator in [7:4], destination in [3:0] |
| frame_done | input | 1 | One-cycle pulse at the end of the frame |
| own_map | input | 15 | Own logical addresses; bit k enables address k |
| listen_all | input | 1 | 1 selects full listening mode, 0 selects reduced |
| cfg_stop_on_rise | input | 1 | End the reception on a rising error |
| cfg_ebit_rise | input | 1 | Send an error bit on a rising error |
| cfg_ebit_long | input | 1 | Send an error bit on a long-period error |
| cfg_bcast_no_ebit | input | 1 | Suppress error bits on broadcast frames |
| err_rise | input | 1 | Rising-error pulse from the timing receiver |
| err_short | input | 1 | Short-period error pulse |
| err_long | input | 1 | Long-period error pulse |
| flag_clr | input | 3 | Write-1 clear for err_flags |
| accept | output | 1 | The current frame is being received |
| ack_drive | output | 1 | Pull the acknowledge bit low for this frame |
| err_bit_req | output | 1 | One-cycle request to send an error bit |
| rx_stop | output | 1 | One-cycle pulse: the reception is ended by an error |
| err_flags | output | 3 | Sticky error flags (rising, short, long) |

## Verification
Every result of this block is registered once. accept and ack_drive change one clock edge after hdr_valid or frame_done. err_bit_req, rx_stop and the flag bits change one edge after the error pulse or clear that caused them. The bench drives each stimulus at a falling edge, removes it at the next falling edge, and samples the outputs at that same point, half a period after the one register has loaded. Tests for absence (no error bit, no stop, an unchanged flag) are sampled in that same cycle, before any later stimulus is applied.

// File: rtl/cec_pol_pkg.sv
package cec_pol_pkg;
  localparam int ERR_RISE  = 0;
  localparam int ERR_SHORT = 1;
  localparam int ERR_LONG  = 2;
  localparam int NUM_ERR   = 3;

  // Error-handling configuration as seen by the policy logic
  typedef struct packed {
    logic stop_on_rise;
    logic ebit_rise;
    logic ebit_long;
    logic bcast_no_ebit;
  } err_cfg_t;

  // Context captured at the header of the current frame
  typedef struct packed {
    logic active;  // frame accepted and still in progress
    logic bcast;   // destination is the broadcast address
    logic own;     // destination is one of the own addresses
    logic full;    // full listening mode at header time
  } frame_ctx_t;
endpackage

// File: rtl/cec_addr_match.sv
module cec_addr_match #(
  parameter int ADDR_W = 4
) (
  input  logic [2*ADDR_W-1:0]        hdr_byte,
  input  logic [(1<<ADDR_W)-2:0]     own_map,
  output logic                       is_bcast,
  output logic                       own_hit
);
  localparam int NUM_ADDR = (1 << ADDR_W) - 1;

  logic [ADDR_W-1:0]   dest;
  logic [NUM_ADDR-1:0] hit_vec;

  assign dest     = hdr_byte[ADDR_W-1:0];
  assign is_bcast = &dest;

  // One comparator per possible own address
  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_cmp
    assign hit_vec[k] = own_map[k] & (dest == ADDR_W'(k));
  end

  assign own_hit = |hit_vec;
endmodule

// File: rtl/cec_frame_ctx.sv
module cec_frame_ctx
  import cec_pol_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_valid,
  input  logic       is_bcast,
  input  logic       own_hit,
  input  logic       listen_all,
  input  logic       frame_done,
  input  logic       stop_now,
  output frame_ctx_t ctx_q
);
  frame_ctx_t ctx_d;
  logic       ctx_en;
  logic       take;

  assign take   = is_bcast | own_hit | listen_all;
  assign ctx_en = hdr_valid | frame_done | stop_now;

  always_comb begin
    ctx_d = ctx_q;
    if (hdr_valid) begin
      ctx_d.active = take;
      ctx_d.bcast  = is_bcast;
      ctx_d.own    = own_hit & ~is_bcast;
      ctx_d.full   = listen_all;
    end else if (frame_done | stop_now) begin
      ctx_d.active = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
    end else if (ctx_en) begin
      ctx_q <= ctx_d;
    end
  end

  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !hdr_valid |=> !ctx_q.active); // R4
endmodule

// File: rtl/cec_err_policy.sv
module cec_err_policy
  import cec_pol_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  frame_ctx_t         ctx,
  input  err_cfg_t           cfg,
  input  logic               hdr_valid,
  input  logic               err_rise,
  input  logic               err_short,
  input  logic               err_long,
  output logic               stop_now,
  output logic [NUM_ERR-1:0] err_seen,
  output logic               ebit_q,
  output logic               stop_q
);
  logic live, involved;
  logic rise_ok, short_ok, long_ok;
  logic ebit_d, stop_d, pulse_en;

  // Errors count only inside an accepted frame, never on a header cycle
  assign live     = ctx.active & ~hdr_valid;
  assign involved = ctx.own | ctx.bcast;

  assign err_seen[ERR_RISE]  = live & err_rise;
  assign err_seen[ERR_SHORT] = live & err_short;
  assign err_seen[ERR_LONG]  = live & err_long;

  assign stop_now = err_seen[ERR_RISE] & cfg.stop_on_rise;

  // Per-error permission; the broadcast override beats the per-error enables
  always_comb begin
    if (ctx.bcast) begin
      rise_ok  = cfg.stop_on_rise & ~cfg.bcast_no_ebit;
      long_ok  = ~cfg.bcast_no_ebit;
      short_ok = ~ctx.full;
    end else begin
      rise_ok  = cfg.stop_on_rise & cfg.ebit_rise;
      long_ok  = cfg.ebit_long;
      short_ok = 1'b1;
    end
  end

  assign ebit_d = involved & ((err_seen[ERR_RISE]  & rise_ok)  |
                              (err_seen[ERR_SHORT] & short_ok) |
                              (err_seen[ERR_LONG]  & long_ok));
  assign stop_d   = stop_now;
  assign pulse_en = ebit_d | stop_d | ebit_q | stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ebit_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (pulse_en) begin
      ebit_q <= ebit_d;
      stop_q <= stop_d;
    end
  end

  AST_EBIT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ebit_q |-> $past(err_rise | err_short | err_long)); // R10
  AST_EBIT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ebit_q |-> $past(ctx.active)); // R10
endmodule

// File: rtl/cec_err_flags.sv
module cec_err_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic nxt, en;
    assign en  = set_i[i] | clr_i[i];
    assign nxt = set_i[i] | (flags_q[i] & ~clr_i[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[i] <= 1'b0;
      end else if (en) begin
        flags_q[i] <= nxt;
      end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[i] && !clr_i[i] |=> flags_q[i]); // R11
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_q[i]); // R11
  end
endmodule

// File: rtl/cec_rx_policy.sv
module cec_rx_policy
  import cec_pol_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  input  logic [2*ADDR_W-1:0]    hdr_byte,
  input  logic                   frame_done,
  input  logic [(1<<ADDR_W)-2:0] own_map,
  input  logic                   listen_all,
  input  logic                   cfg_stop_on_rise,
  input  logic                   cfg_ebit_rise,
  input  logic                   cfg_ebit_long,
  input  logic                   cfg_bcast_no_ebit,
  input  logic                   err_rise,
  input  logic                   err_short,
  input  logic                   err_long,
  input  logic [2:0]             flag_clr,
  output logic                   accept,
  output logic                   ack_drive,
  output logic                   err_bit_req,
  output logic                   rx_stop,
  output logic [2:0]             err_flags
);
  localparam int NUM_ADDR = (1 << ADDR_W) - 1;

  logic               is_bcast, own_hit, stop_now;
  logic [NUM_ERR-1:0] err_seen;
  frame_ctx_t         ctx_q;
  err_cfg_t           cfg;

  assign cfg.stop_on_rise  = cfg_stop_on_rise;
  assign cfg.ebit_rise     = cfg_ebit_rise;
  assign cfg.ebit_long     = cfg_ebit_long;
  assign cfg.bcast_no_ebit = cfg_bcast_no_ebit;

  cec_addr_match #(.ADDR_W(ADDR_W)) i_match (
    .hdr_byte (hdr_byte),
    .own_map  (own_map),
    .is_bcast (is_bcast),
    .own_hit  (own_hit)
  );

  cec_frame_ctx i_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_valid  (hdr_valid),
    .is_bcast   (is_bcast),
    .own_hit    (own_hit),
    .listen_all (listen_all),
    .frame_done (frame_done),
    .stop_now   (stop_now),
    .ctx_q      (ctx_q)
  );

  cec_err_policy i_pol (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctx       (ctx_q),
    .cfg       (cfg),
    .hdr_valid (hdr_valid),
    .err_rise  (err_rise),
    .err_short (err_short),
    .err_long  (err_long),
    .stop_now  (stop_now),
    .err_seen  (err_seen),
    .ebit_q    (err_bit_req),
    .stop_q    (rx_stop)
  );

  cec_err_flags #(.N(NUM_ERR)) i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (err_seen),
    .clr_i   (flag_clr),
    .flags_q (err_flags)
  );

  assign accept    = ctx_q.active;
  assign ack_drive = ctx_q.active & ctx_q.own;

  // Observation-only decode used by the assertions below
  logic [NUM_ADDR:0]  own_ext;
  logic [ADDR_W-1:0]  dest_obs;
  assign own_ext  = {1'b0, own_map};
  assign dest_obs = hdr_byte[ADDR_W-1:0];

  AST_REDUCED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !listen_all && !(&dest_obs) && !own_ext[dest_obs] |=> !accept); // R1
  AST_FULL_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && listen_all |=> accept); // R2
  AST_BCAST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && (&dest_obs) |=> !ack_drive); // R3
  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop |-> !accept); // R5
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop |=> !rx_stop); // R5
endmodule

// File: tb/test_cec_rx_policy.sv
module test_cec_rx_policy;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hdr_valid, frame_done, listen_all;
  logic [7:0]  hdr_byte;
  logic [14:0] own_map;
  logic        cfg_stop_on_rise, cfg_ebit_rise, cfg_ebit_long, cfg_bcast_no_ebit;
  logic        err_rise, err_short, err_long;
  logic [2:0]  flag_clr;
  logic        accept, ack_drive, err_bit_req, rx_stop;
  logic [2:0]  err_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  cec_rx_policy i_cec_rx_policy (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
    .frame_done(frame_done), .own_map(own_map), .listen_all(listen_all),
    .cfg_stop_on_rise(cfg_stop_on_rise), .cfg_ebit_rise(cfg_ebit_rise),
    .cfg_ebit_long(cfg_ebit_long), .cfg_bcast_no_ebit(cfg_bcast_no_ebit),
    .err_rise(err_rise), .err_short(err_short), .err_long(err_long),
    .flag_clr(flag_clr), .accept(accept), .ack_drive(ack_drive),
    .err_bit_req(err_bit_req), .rx_stop(rx_stop), .err_flags(err_flags)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic send_hdr(input logic [7:0] b);
    hdr_byte = b; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic close_frame();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic err_pulse(input logic r, input logic s, input logic l);
    err_rise = r; err_short = s; err_long = l;
    @(negedge clk);
    err_rise = 1'b0; err_short = 1'b0; err_long = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  task automatic set_cfg(input logic st, input logic er, input logic el, input logic nb);
    cfg_stop_on_rise = st; cfg_ebit_rise = er; cfg_ebit_long = el; cfg_bcast_no_ebit = nb;
  endtask

  task automatic t_reset();
    chk("R4 reset accept", accept, 0);
    chk("R3 reset ack_drive", ack_drive, 0);
    chk("R5 reset rx_stop", rx_stop, 0);
    chk("R10 reset err_bit_req", err_bit_req, 0);
    chk("R11 reset err_flags", err_flags, 0);
  endtask

  task automatic t_reduced();
    listen_all = 0; own_map = 15'h0208; // addresses 3 and 9
    send_hdr(8'h43); chk("R1 own addr 3 accept", accept, 1); chk("R3 own addr 3 ack", ack_drive, 1); close_frame();
    send_hdr(8'h49); chk("R2 second own addr 9 accept", accept, 1); chk("R3 own addr 9 ack", ack_drive, 1); close_frame();
    send_hdr(8'h45); chk("R1 foreign addr 5 rejected", accept, 0); chk("R3 foreign no ack", ack_drive, 0);
    send_hdr(8'h0E); chk("R1 addr 14 not own rejected", accept, 0);
    send_hdr(8'h4F); chk("R1 broadcast accept", accept, 1); chk("R3 broadcast no ack", ack_drive, 0); close_frame();
    send_hdr(8'hA3); chk("R12 other initiator accept", accept, 1); chk("R12 other initiator ack", ack_drive, 1); close_frame();
    send_hdr(8'hA5); chk("R12 other initiator foreign rejected", accept, 0);
  endtask

  task automatic t_full();
    listen_all = 1; own_map = 15'h0208;
    send_hdr(8'h45); chk("R2 full foreign accept", accept, 1); chk("R3 full foreign no ack", ack_drive, 0); close_frame();
    send_hdr(8'h13); chk("R2 full own accept", accept, 1); chk("R3 full own ack", ack_drive, 1); close_frame();
    listen_all = 0;
  endtask

  task automatic t_hold();
    send_hdr(8'h43);
    repeat (5) @(negedge clk);
    chk("R4 accept held", accept, 1); chk("R4 ack held", ack_drive, 1);
    close_frame();
    chk("R4 accept dropped after frame_done", accept, 0); chk("R4 ack dropped", ack_drive, 0);
  endtask

  task automatic t_rise();
    set_cfg(1, 1, 0, 0); send_hdr(8'h43); err_pulse(1, 0, 0);
    chk("R6 rise ebit stop+enable", err_bit_req, 1); chk("R5 rx_stop pulse", rx_stop, 1);
    chk("R5 accept dropped on stop", accept, 0);
    @(negedge clk); chk("R5 rx_stop single cycle", rx_stop, 0);
    set_cfg(0, 1, 0, 0); send_hdr(8'h43); err_pulse(1, 0, 0);
    chk("R6 no ebit without stop", err_bit_req, 0); chk("R5 no stop when disabled", rx_stop, 0);
    chk("R5 reception continues", accept, 1); close_frame();
    set_cfg(1, 0, 0, 0); send_hdr(8'h43); err_pulse(1, 0, 0);
    chk("R6 no ebit with enable clear", err_bit_req, 0); chk("R5 stop still fires", rx_stop, 1);
  endtask

  task automatic t_long();
    set_cfg(0, 0, 1, 0); send_hdr(8'h49); err_pulse(0, 0, 1);
    chk("R7 long ebit enabled", err_bit_req, 1); chk("R7 long no stop", rx_stop, 0); chk("R7 frame kept", accept, 1);
    set_cfg(0, 0, 0, 0); err_pulse(0, 0, 1);
    chk("R7 long ebit disabled", err_bit_req, 0); close_frame();
  endtask

  task automatic t_bcast();
    set_cfg(1, 0, 0, 0); send_hdr(8'h4F); err_pulse(1, 0, 0);
    chk("R8 bcast rise ebit despite enable clear", err_bit_req, 1);
    set_cfg(0, 0, 0, 0); send_hdr(8'h4F); err_pulse(0, 0, 1);
    chk("R8 bcast long ebit despite enable clear", err_bit_req, 1);
    set_cfg(0, 0, 1, 1); err_pulse(0, 0, 1);
    chk("R8 override beats long enable", err_bit_req, 0); close_frame();
    set_cfg(1, 1, 0, 1); send_hdr(8'h4F); err_pulse(1, 0, 0);
    chk("R8 override beats rise enable", err_bit_req, 0); chk("R5 bcast stop still", rx_stop, 1);
  endtask

  task automatic t_short();
    set_cfg(0, 0, 0, 0); listen_all = 0;
    send_hdr(8'h43); err_pulse(0, 1, 0); chk("R9 short own ebit", err_bit_req, 1); close_frame();
    send_hdr(8'h4F); err_pulse(0, 1, 0); chk("R9 short bcast reduced ebit", err_bit_req, 1); close_frame();
    listen_all = 1;
    send_hdr(8'h4F); err_pulse(0, 1, 0); chk("R9 short bcast full no ebit", err_bit_req, 0); close_frame();
    set_cfg(1, 1, 1, 0);
    send_hdr(8'h45); err_pulse(1, 1, 1); chk("R10 foreign full no ebit", err_bit_req, 0);
    chk("R11 foreign full flags set", err_flags, 3'b111); close_frame();
    listen_all = 0;
  endtask

  task automatic t_idle();
    set_cfg(1, 1, 1, 0); clear_flags();
    err_pulse(1, 1, 1);
    chk("R10 idle no ebit", err_bit_req, 0); chk("R10 idle no stop", rx_stop, 0);
    chk("R10 idle flags untouched", err_flags, 0);
    hdr_byte = 8'h43; hdr_valid = 1; err_long = 1;
    @(negedge clk); hdr_valid = 0; err_long = 0;
    chk("R10 error on header cycle ignored", err_bit_req, 0);
    chk("R10 header-cycle flags untouched", err_flags, 0); close_frame();
  endtask

  task automatic t_flags();
    set_cfg(0, 0, 0, 0); clear_flags(); send_hdr(8'h43);
    err_pulse(1, 0, 0); chk("R11 rise flag set", err_flags, 3'b001);
    repeat (3) @(negedge clk); chk("R11 flag sticky", err_flags, 3'b001);
    err_pulse(0, 0, 1); chk("R11 long flag added", err_flags, 3'b101);
    flag_clr = 3'b001; @(negedge clk); flag_clr = 0;
    chk("R11 write-1 clear bit 0 only", err_flags, 3'b100);
    err_short = 1; flag_clr = 3'b010; @(negedge clk); err_short = 0; flag_clr = 0;
    chk("R11 set wins over clear", err_flags, 3'b110);
    close_frame();
  endtask

  initial begin
    rst_n = 0; hdr_valid = 0; hdr_byte = 0; frame_done = 0; own_map = 0; listen_all = 0;
    err_rise = 0; err_short = 0; err_long = 0; flag_clr = 0;
    set_cfg(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reduced();
    t_full();
    t_hold();
    t_rise();
    t_long();
    t_bcast();
    t_short();
    t_idle();
    t_flags();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule